// File: doc/BRIEF.md
# System Control Register File with Interrupt Aggregation

This block is the byte-wide control register space of a multifunction I/O companion device. A host reaches it through an 8-bit address and 8-bit data port with single-byte accesses. Writes commit on the clock edge. Reads are combinational from the current address.

Eight sub-unit interrupt lines are captured into a status byte every cycle. That byte is masked and reduced to one interrupt output. Sixteen general-purpose output pins are driven from byte-wide data and enable registers. The level each pin actually drives is its data bit gated by its enable bit. After a write to either register, a one-cycle strobe marks every pin whose gated level moved.

The rest of the space is plain stored setup: a routing byte, a configuration byte, and several 16-bit and 32-bit clock and mode words. These words are reached one byte lane at a time, least significant byte at the lowest offset. A fixed revision code occupies two read-only bytes. Every other offset reads as zero and ignores writes.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset, every writable register reads 0. Interrupt output, pin levels and pin strobes are all 0.
- R2: Offset 0x08 always reads 0x03 and offset 0x09 always reads 0x00. Writes to either have no effect.
- R3: The status byte at offset 0x50 takes the value of the eight sub-unit interrupt inputs at each clock edge. Bit i follows input i.
- R4: The interrupt output is high exactly when the status byte ANDed with the mask byte at offset 0x52 is nonzero.
- R5: A write to offset 0x50 loads the written byte for one cycle. At the next edge, the status byte again follows the live inputs.
- R6: Output data lanes sit at offsets 0x78, 0x79 and 0x7A, and output enable lanes at 0x7C, 0x7D and 0x7E. Lane n holds pin bits 8n+7:8n, and each lane reads back what was written.
- R7: The pin level output for pin i equals data bit i AND enable bit i, for pins 0 to 15. Lane 2 bits never reach a pin.
- R8: In the cycle after a write to any data or enable lane, the strobe output has bit i set exactly for the pins whose gated level changed. In every other cycle the strobe output is 0.
- R9: The 32-bit word at offsets 0x9C to 0x9F and the 16-bit words at 0x98, 0x9A and 0xE4 are little-endian. A byte write to one offset changes only that byte.
- R10: A read from an unmapped offset, such as 0x00, 0x40, 0x51 or 0x7B, returns 0. A write to it changes nothing readable.
- R11: The routing byte at offset 0x54 and the configuration byte at offset 0xFC store and read back the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte offset for read and write |
| wr_i | input | 1 | Write strobe, commits wdata_i at the clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| src_irq_i | input | 8 | Sub-unit interrupt levels |
| irq_o | output | 1 | Combined masked interrupt |
| pin_lvl_o | output | 16 | Gated pin levels |
| pin_evt_o | output | 16 | One-cycle change strobes per pin |

## Verification
The gating logic is tested with four kinds of write: enable-only writes while data is zero, data writes into enabled lanes, a repeat of the same data, and an enable write that turns off part of an active lane. Only the second and fourth may raise strobes, and each must raise exactly the pins that moved. Interrupt aggregation is tested with inputs that have one bit inside the mask and one bit outside it, then with the mask moved onto the other bit. This shows that masking, and not the raw status byte, drives the output. A direct status write is read back in its one cycle and again in the following cycle, which separates a held value from one that the live inputs overwrite.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int AW        = 8;
  localparam int DW        = 8;
  localparam int NUM_SRC   = 8;
  localparam int NUM_PINS  = 16;
  localparam int GPIO_LANES = 3;

  localparam logic [AW-1:0] OFF_REV_LO = 8'h08;
  localparam logic [AW-1:0] OFF_REV_HI = 8'h09;
  localparam logic [DW-1:0] REV_LO_VAL = 8'h03;
  localparam logic [DW-1:0] REV_HI_VAL = 8'h00;
  localparam logic [AW-1:0] OFF_STATUS = 8'h50;
  localparam logic [AW-1:0] OFF_MASK   = 8'h52;
  localparam logic [AW-1:0] OFF_DATA0  = 8'h78;
  localparam logic [AW-1:0] OFF_OEN0   = 8'h7C;

  // plain stored bytes: route, clock word, pll words, mode word, config
  localparam int NCFG = 12;
  localparam logic [NCFG*AW-1:0] CFG_ADDRS = {
    8'hFC, 8'hE5, 8'hE4, 8'h9F, 8'h9E, 8'h9D,
    8'h9C, 8'h9B, 8'h9A, 8'h99, 8'h98, 8'h54
  };
endpackage

// File: rtl/sysctl_irq_agg.sv
module sysctl_irq_agg
  import sysctl_pkg::*;
#(
  parameter int NSRC = NUM_SRC
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [NSRC-1:0] wdata_i,
  input  logic [NSRC-1:0] src_i,
  output logic [NSRC-1:0] status_o,
  output logic [NSRC-1:0] mask_o,
  output logic            irq_o
);
  logic [NSRC-1:0] status_q, mask_q;

  // direct write wins for one edge, live inputs otherwise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= (wr_i && addr_i == OFF_STATUS) ? wdata_i : src_i;
      if (wr_i && addr_i == OFF_MASK) mask_q <= wdata_i;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & mask_q);
endmodule

// File: rtl/sysctl_gpio_out.sv
module sysctl_gpio_out
  import sysctl_pkg::*;
#(
  parameter int LANES = GPIO_LANES,
  parameter int NPINS = NUM_PINS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic [NPINS-1:0] lvl_o,
  output logic [NPINS-1:0] evt_o
);
  localparam int W = LANES * DW;

  logic [W-1:0]     data_q, oen_q, data_d, oen_d;
  logic [NPINS-1:0] lvl_q, evt_q, eff_d;
  logic             any_wr;

  always_comb begin
    data_d = data_q;
    oen_d  = oen_q;
    any_wr = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (wr_i && addr_i == OFF_DATA0 + AW'(l)) begin
        data_d[l*DW +: DW] = wdata_i;
        any_wr = 1'b1;
      end
      if (wr_i && addr_i == OFF_OEN0 + AW'(l)) begin
        oen_d[l*DW +: DW] = wdata_i;
        any_wr = 1'b1;
      end
    end
  end

  assign eff_d = data_d[NPINS-1:0] & oen_d[NPINS-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      oen_q  <= '0;
      lvl_q  <= '0;
      evt_q  <= '0;
    end else begin
      data_q <= data_d;
      oen_q  <= oen_d;
      if (any_wr) begin
        evt_q <= eff_d ^ lvl_q;
        lvl_q <= eff_d;
      end else begin
        evt_q <= '0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int l = 0; l < LANES; l++) begin
      if (addr_i == OFF_DATA0 + AW'(l)) rdata_o = data_q[l*DW +: DW];
      if (addr_i == OFF_OEN0 + AW'(l))  rdata_o = oen_q[l*DW +: DW];
    end
  end

  assign lvl_o = lvl_q;
  assign evt_o = evt_q;
endmodule

// File: rtl/sysctl_cfg_bank.sv
module sysctl_cfg_bank
  import sysctl_pkg::*;
#(
  parameter int                  N     = NCFG,
  parameter logic [N*AW-1:0]     ADDRS = CFG_ADDRS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] byte_q [N];

  // one register per byte lane; multi-byte words are just adjacent lanes
  for (genvar e = 0; e < N; e++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    byte_q[e] <= '0;
      else if (wr_i && addr_i == ADDRS[e*AW +: AW])   byte_q[e] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int e = 0; e < N; e++)
      if (addr_i == ADDRS[e*AW +: AW]) rdata_o = byte_q[e];
  end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [AW-1:0]       addr_i,
  input  logic                wr_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  input  logic [NUM_SRC-1:0]  src_irq_i,
  output logic                irq_o,
  output logic [NUM_PINS-1:0] pin_lvl_o,
  output logic [NUM_PINS-1:0] pin_evt_o
);
  logic [NUM_SRC-1:0] status_w, mask_w;
  logic [DW-1:0]      gpio_rd, cfg_rd;

  sysctl_irq_agg #(.NSRC(NUM_SRC)) u_irq (
    .clk_i, .rst_ni, .wr_i, .addr_i,
    .wdata_i (wdata_i[NUM_SRC-1:0]),
    .src_i   (src_irq_i),
    .status_o(status_w),
    .mask_o  (mask_w),
    .irq_o   (irq_o)
  );

  sysctl_gpio_out #(.LANES(GPIO_LANES), .NPINS(NUM_PINS)) u_gpio (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .rdata_o(gpio_rd),
    .lvl_o  (pin_lvl_o),
    .evt_o  (pin_evt_o)
  );

  sysctl_cfg_bank #(.N(NCFG), .ADDRS(CFG_ADDRS)) u_cfg (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .rdata_o(cfg_rd)
  );

  // unclaimed offsets fall through to zero
  always_comb begin
    unique case (addr_i)
      OFF_REV_LO: rdata_o = REV_LO_VAL;
      OFF_REV_HI: rdata_o = REV_HI_VAL;
      OFF_STATUS: rdata_o = DW'(status_w);
      OFF_MASK:   rdata_o = DW'(mask_w);
      default:    rdata_o = gpio_rd | cfg_rd;
    endcase
  end
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk
  import sysctl_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic [AW-1:0]       addr_i,
  input logic                wr_i,
  input logic [DW-1:0]       wdata_i,
  input logic [DW-1:0]       rdata_o,
  input logic [NUM_SRC-1:0]  src_irq_i,
  input logic [NUM_SRC-1:0]  status_w,
  input logic [NUM_SRC-1:0]  mask_w,
  input logic                irq_o,
  input logic [NUM_PINS-1:0] pin_lvl_o,
  input logic [NUM_PINS-1:0] pin_evt_o
);
  a_r3_status_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == OFF_STATUS) |=> status_w == $past(src_irq_i));

  a_r5_direct_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFF_STATUS) |=> status_w == $past(wdata_i[NUM_SRC-1:0]));

  a_r4_irq_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|status_w && |mask_w));

  a_r4_zero_mask_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_w == '0) |-> !irq_o);

  a_r8_evt_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pin_evt_o) |-> $past(wr_i));

  a_r8_evt_is_delta: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> pin_evt_o == (pin_lvl_o ^ $past(pin_lvl_o)));

  a_r2_revid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFF_REV_LO) |-> rdata_o == REV_LO_VAL);

  a_r10_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 8'h40) |-> rdata_o == '0);
endmodule

bind sysctl_regfile sysctl_regfile_chk u_chk (
  .clk_i, .rst_ni, .addr_i, .wr_i, .wdata_i, .rdata_o, .src_irq_i,
  .status_w, .mask_w, .irq_o, .pin_lvl_o, .pin_evt_o
);

// File: tb/sysctl_regfile_tb_top.sv
`timescale 1ns/1ps
module sysctl_regfile_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        wr_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic [7:0]  src_irq_i = '0;
  logic        irq_o;
  logic [15:0] pin_lvl_o, pin_evt_o;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  sysctl_regfile dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr_i = a;
    #0.5;
    d = rdata_o;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    foreach (v[i]) ; // no-op keeps v referenced
    rd(8'h50, v); chk("R1 status", v, 0);
    rd(8'h52, v); chk("R1 mask", v, 0);
    rd(8'h78, v); chk("R1 data0", v, 0);
    rd(8'h7C, v); chk("R1 oen0", v, 0);
    rd(8'h9C, v); chk("R1 pll lo", v, 0);
    rd(8'hFC, v); chk("R1 config", v, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 lvl", pin_lvl_o, 0);
    chk("R1 evt", pin_evt_o, 0);
  endtask

  task automatic t_revid;
    logic [7:0] v;
    rd(8'h08, v); chk("R2 rev lo", v, 8'h03);
    rd(8'h09, v); chk("R2 rev hi", v, 8'h00);
    wr(8'h08, 8'hFF); wr(8'h09, 8'h55);
    rd(8'h08, v); chk("R2 rev lo after write", v, 8'h03);
    rd(8'h09, v); chk("R2 rev hi after write", v, 8'h00);
  endtask

  task automatic t_status;
    logic [7:0] v;
    @(negedge clk_i); src_irq_i = 8'hA5;
    @(negedge clk_i); rd(8'h50, v); chk("R3 status A5", v, 8'hA5);
    @(negedge clk_i); src_irq_i = 8'h3C;
    @(negedge clk_i); rd(8'h50, v); chk("R3 status 3C", v, 8'h3C);
  endtask

  task automatic t_direct;
    logic [7:0] v;
    @(negedge clk_i); src_irq_i = 8'h0F;
    wr(8'h50, 8'hA0);
    rd(8'h50, v); chk("R5 direct write held", v, 8'hA0);
    @(negedge clk_i); rd(8'h50, v); chk("R5 overridden by inputs", v, 8'h0F);
  endtask

  task automatic t_irq;
    @(negedge clk_i); src_irq_i = 8'h81;
    wr(8'h52, 8'h01);
    chk("R4 masked bit set", irq_o, 1);
    src_irq_i = 8'h80;
    @(negedge clk_i); chk("R4 unmasked bit only", irq_o, 0);
    wr(8'h52, 8'h80);
    chk("R4 mask moved", irq_o, 1);
    wr(8'h52, 8'h00);
    chk("R4 zero mask", irq_o, 0);
    src_irq_i = 8'h00;
  endtask

  task automatic t_gpio;
    logic [7:0] v;
    wr(8'h7C, 8'hFF);
    chk("R8 enable with zero data", pin_evt_o, 16'h0000);
    wr(8'h78, 8'h5A);
    chk("R8 data lane0 strobe", pin_evt_o, 16'h005A);
    chk("R7 level lane0", pin_lvl_o, 16'h005A);
    @(negedge clk_i); chk("R8 strobe one cycle", pin_evt_o, 16'h0000);
    wr(8'h78, 8'h5A);
    chk("R8 same data no strobe", pin_evt_o, 16'h0000);
    wr(8'h7D, 8'h0F);
    chk("R8 enable lane1 zero data", pin_evt_o, 16'h0000);
    wr(8'h79, 8'hFF);
    chk("R8 data lane1 strobe", pin_evt_o, 16'h0F00);
    chk("R7 level gated lane1", pin_lvl_o, 16'h0F5A);
    wr(8'h7C, 8'h0F);
    chk("R8 enable cut strobe", pin_evt_o, 16'h0050);
    chk("R7 level after cut", pin_lvl_o, 16'h0F0A);
    wr(8'h7A, 8'hFF); wr(8'h7E, 8'hFF);
    chk("R7 lane2 no pin", pin_lvl_o, 16'h0F0A);
    chk("R8 lane2 no strobe", pin_evt_o, 16'h0000);
    rd(8'h78, v); chk("R6 data0 readback", v, 8'h5A);
    rd(8'h79, v); chk("R6 data1 readback", v, 8'hFF);
    rd(8'h7A, v); chk("R6 data2 readback", v, 8'hFF);
    rd(8'h7D, v); chk("R6 oen1 readback", v, 8'h0F);
  endtask

  task automatic t_lanes;
    logic [7:0] v;
    wr(8'h9E, 8'h77);
    rd(8'h9C, v); chk("R9 pll b0", v, 0);
    rd(8'h9D, v); chk("R9 pll b1", v, 0);
    rd(8'h9E, v); chk("R9 pll b2", v, 8'h77);
    rd(8'h9F, v); chk("R9 pll b3", v, 0);
    wr(8'h9C, 8'h11);
    rd(8'h9E, v); chk("R9 pll b2 kept", v, 8'h77);
    rd(8'h9C, v); chk("R9 pll b0 set", v, 8'h11);
    wr(8'h99, 8'hC3);
    rd(8'h98, v); chk("R9 clk lo untouched", v, 0);
    rd(8'h99, v); chk("R9 clk hi", v, 8'hC3);
    wr(8'hE4, 8'h3E);
    rd(8'hE4, v); chk("R9 mode lo", v, 8'h3E);
    rd(8'hE5, v); chk("R9 mode hi untouched", v, 0);
  endtask

  task automatic t_single;
    logic [7:0] v;
    wr(8'h54, 8'h96); rd(8'h54, v); chk("R11 route", v, 8'h96);
    wr(8'hFC, 8'h6B); rd(8'hFC, v); chk("R11 config", v, 8'h6B);
  endtask

  task automatic t_unmapped;
    logic [7:0] v;
    wr(8'h40, 8'hFF); rd(8'h40, v); chk("R10 0x40", v, 0);
    wr(8'h51, 8'hFF); rd(8'h51, v); chk("R10 0x51", v, 0);
    wr(8'h7B, 8'hFF); rd(8'h7B, v); chk("R10 0x7B", v, 0);
    chk("R10 pins unchanged", pin_lvl_o, 16'h0F0A);
    rd(8'h00, v); chk("R10 0x00", v, 0);
    rd(8'h54, v); chk("R10 route kept", v, 8'h96);
  endtask

  initial begin : wdog
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_revid;
    t_status;
    t_direct;
    t_irq;
    t_gpio;
    t_lanes;
    t_single;
    t_unmapped;
    @(negedge clk_i);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule